// File: doc/BRIEF.md
# Load/store debug watchpoint matcher

The block observes load/store bus cycles and raises debug events when a cycle meets a programmable condition. It has four comparators. Two compare the bus address with reference values. Two compare the bus data with reference values. Each comparator is set to equal, not equal, greater than or less than. The two data comparators can also be set to treat their operands as two's-complement numbers.

The two comparators of a kind can work as a pair and act as one strict in-range or out-of-range detector. An AND-OR network then forms two load/store watchpoints. Each watchpoint needs its enable, and it can also need a set of the four incoming instruction watchpoint flags, an address term and a data term. Any chosen subset of the watchpoints triggers the load/store breakpoint. When the breakpoint fires, the address of the cycle that caused it is latched in a breakpoint address register. Watchpoints are also driven on active-low pins.

All results are registered. They appear one clock after the bus cycle is presented, so the block adds no delay to the bus path itself.

Top module: `lsw_match_unit`

## Requirements
- R1: While rst_ni is low, lsw_o and bp_o are 0, lsw_pin_n_o is all ones and bar_o is 0.
- R2: Comparator k has its operation in cmp_op_i[2k+1:2k], with 0=equal, 1=not equal, 2=greater than (bus value > reference) and 3=less than. k=0 is address A, k=1 address B, k=2 data A, k=3 data B. Address compares are unsigned. Every result shows on the outputs one clock after the cycle is sampled.
- R3: Bit g of data_signed_i selects a two's-complement comparison for data comparator g (0=A, 1=B). When the bit is 0 the comparison is unsigned.
- R4: addr_pair_i and data_pair_i each set how their pair works. 0 or 3 means the two comparators work on their own. 1 means in-range: both results become (value > ref A) and (value < ref B), each half using its own comparator's signedness. 2 means out-of-range, which is the complement of in-range. In pair modes the op fields are ignored.
- R5: bus_size_i gives the access size: 0=byte, 1=half-word, 2=word, 3=no match. A half-word with bus_addr_i[0]=1 produces no watchpoint. A word with bus_addr_i[1:0]!=0 produces no watchpoint.
- R6: Watchpoint k needs wp_en_i[k]. Its instruction mask is wp_iw_mask_i[4k+3:4k]. A zero mask means no condition; otherwise at least one masked iw_i bit must be high. It also needs its address term, selected by wp_addr_sel_i[2k+1:2k], and its data term, selected by wp_data_sel_i[2k+1:2k]. For both terms the codes are 0=always true, 1=comparator A, 2=comparator B, 3=A or B.
- R7: No watchpoint or breakpoint is produced for a clock in which bus_valid_i is low.
- R8: bp_o is high exactly when a watchpoint k with bp_sel_i[k]=1 fires. It appears in the same clock as lsw_o.
- R9: lsw_pin_n_o is always the bitwise inverse of lsw_o.
- R10: bar_o loads bus_addr_i of the cycle that causes a breakpoint, in the same clock in which bp_o rises. Otherwise bar_wr_i loads bar_wdata_i. A breakpoint takes priority over a write. With neither, bar_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | A load/store cycle is present |
| bus_addr_i | input | 32 | Cycle address |
| bus_data_i | input | 32 | Cycle data |
| bus_size_i | input | 2 | Access size code |
| iw_i | input | 4 | Instruction watchpoint flags |
| addr_ref_a_i | input | 32 | Address reference A |
| addr_ref_b_i | input | 32 | Address reference B |
| data_ref_a_i | input | 32 | Data reference A |
| data_ref_b_i | input | 32 | Data reference B |
| cmp_op_i | input | 8 | Comparator operations |
| data_signed_i | input | 2 | Signed mode for data comparators |
| addr_pair_i | input | 2 | Address pair mode |
| data_pair_i | input | 2 | Data pair mode |
| wp_en_i | input | 2 | Watchpoint enables |
| wp_iw_mask_i | input | 8 | Instruction flag masks per watchpoint |
| wp_addr_sel_i | input | 4 | Address term select per watchpoint |
| wp_data_sel_i | input | 4 | Data term select per watchpoint |
| bp_sel_i | input | 2 | Watchpoints that raise the breakpoint |
| bar_wr_i | input | 1 | Write strobe for breakpoint address |
| bar_wdata_i | input | 32 | Write value for breakpoint address |
| lsw_o | output | 2 | Load/store watchpoints |
| lsw_pin_n_o | output | 2 | Active-low watchpoint pins |
| bp_o | output | 1 | Load/store breakpoint |
| bar_o | output | 32 | Breakpoint address register |

## Verification
The only state in this block is one output register stage and the breakpoint address. A wrong comparator, pair or network decision therefore shows on lsw_o or bp_o in the clock right after the bus cycle that exposed it. A corrupted breakpoint address shows on bar_o in that same clock and stays visible until the next breakpoint or write. The bench checks every output against a behavioural model on every clock. It uses reference values close to the bus operands so that the boundaries of equality, sign and range are crossed often.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic [1:0] {OP_EQ = 2'd0, OP_NE = 2'd1, OP_GT = 2'd2, OP_LT = 2'd3} cmp_op_e;
  typedef enum logic [1:0] {PAIR_SPLIT = 2'd0, PAIR_IN = 2'd1, PAIR_OUT = 2'd2, PAIR_RSV = 2'd3} pair_mode_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_NONE = 2'd3} acc_size_e;

  function automatic logic access_ok(logic [1:0] size, logic [1:0] lsb);
    case (size)
      SZ_BYTE: access_ok = 1'b1;
      SZ_HALF: access_ok = ~lsb[0];
      SZ_WORD: access_ok = (lsb == 2'b00);
      default: access_ok = 1'b0;
    endcase
  endfunction

  // term select: 0 true, 1 A, 2 B, 3 A|B
  function automatic logic term_sel(logic [1:0] sel, logic [1:0] hit);
    case (sel)
      2'd0:    term_sel = 1'b1;
      2'd1:    term_sel = hit[0];
      2'd2:    term_sel = hit[1];
      default: term_sel = |hit;
    endcase
  endfunction
endpackage

// File: rtl/lsw_cmp.sv
module lsw_cmp
  import lsw_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] ref_i,
  input  logic [1:0]   op_i,
  input  logic         signed_i,
  output logic         hit_o,
  output logic         gt_o,
  output logic         lt_o
);
  logic eq;

  always_comb begin
    eq = (value_i == ref_i);
    if (signed_i) begin
      gt_o = $signed(value_i) > $signed(ref_i);
      lt_o = $signed(value_i) < $signed(ref_i);
    end else begin
      gt_o = value_i > ref_i;
      lt_o = value_i < ref_i;
    end
    case (op_i)
      OP_EQ:   hit_o = eq;
      OP_NE:   hit_o = ~eq;
      OP_GT:   hit_o = gt_o;
      default: hit_o = lt_o;
    endcase
  end
endmodule

// File: rtl/lsw_pair.sv
module lsw_pair
  import lsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] hit_i,
  input  logic [1:0] gt_i,
  input  logic [1:0] lt_i,
  input  logic [1:0] mode_i,
  output logic [1:0] res_o
);
  logic in_rng;

  always_comb begin
    in_rng = gt_i[0] & lt_i[1];
    case (mode_i)
      PAIR_IN:  res_o = {2{in_rng}};
      PAIR_OUT: res_o = {2{~in_rng}};
      default:  res_o = hit_i;
    endcase
  end

  AST_REL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gt_i & lt_i) == 2'b00); // R2
endmodule

// File: rtl/lsw_andor.sv
module lsw_andor
  import lsw_pkg::*;
#(
  parameter int unsigned N_IW = 4,
  parameter int unsigned N_WP = 2
) (
  input  logic                 qual_i,
  input  logic [N_IW-1:0]      iw_i,
  input  logic [1:0]           addr_hit_i,
  input  logic [1:0]           data_hit_i,
  input  logic [N_WP-1:0]      wp_en_i,
  input  logic [N_WP*N_IW-1:0] iw_mask_i,
  input  logic [2*N_WP-1:0]    addr_sel_i,
  input  logic [2*N_WP-1:0]    data_sel_i,
  input  logic [N_WP-1:0]      bp_sel_i,
  output logic [N_WP-1:0]      wp_o,
  output logic                 bp_o
);
  for (genvar k = 0; k < N_WP; k++) begin : g_wp
    logic [N_IW-1:0] mask;
    logic            iw_term;
    assign mask    = iw_mask_i[k*N_IW +: N_IW];
    assign iw_term = (mask == '0) | (|(iw_i & mask));
    assign wp_o[k] = qual_i & wp_en_i[k] & iw_term
                   & term_sel(addr_sel_i[2*k +: 2], addr_hit_i)
                   & term_sel(data_sel_i[2*k +: 2], data_hit_i);
  end

  assign bp_o = |(wp_o & bp_sel_i);
endmodule

// File: rtl/lsw_match_unit.sv
module lsw_match_unit
  import lsw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_IW   = 4,
  parameter int unsigned N_WP   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_valid_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_data_i,
  input  logic [1:0]           bus_size_i,
  input  logic [N_IW-1:0]      iw_i,
  input  logic [ADDR_W-1:0]    addr_ref_a_i,
  input  logic [ADDR_W-1:0]    addr_ref_b_i,
  input  logic [DATA_W-1:0]    data_ref_a_i,
  input  logic [DATA_W-1:0]    data_ref_b_i,
  input  logic [7:0]           cmp_op_i,
  input  logic [1:0]           data_signed_i,
  input  logic [1:0]           addr_pair_i,
  input  logic [1:0]           data_pair_i,
  input  logic [N_WP-1:0]      wp_en_i,
  input  logic [N_WP*N_IW-1:0] wp_iw_mask_i,
  input  logic [2*N_WP-1:0]    wp_addr_sel_i,
  input  logic [2*N_WP-1:0]    wp_data_sel_i,
  input  logic [N_WP-1:0]      bp_sel_i,
  input  logic                 bar_wr_i,
  input  logic [ADDR_W-1:0]    bar_wdata_i,
  output logic [N_WP-1:0]      lsw_o,
  output logic [N_WP-1:0]      lsw_pin_n_o,
  output logic                 bp_o,
  output logic [ADDR_W-1:0]    bar_o
);
  logic [ADDR_W-1:0] addr_ref [2];
  logic [DATA_W-1:0] data_ref [2];
  logic [1:0] a_hit, a_gt, a_lt, a_res;
  logic [1:0] d_hit, d_gt, d_lt, d_res;
  logic       qual;
  logic [N_WP-1:0] wp_d;
  logic       bp_d;

  logic [N_WP-1:0]   lsw_q;
  logic              bp_q;
  logic [ADDR_W-1:0] bar_q;

  assign addr_ref[0] = addr_ref_a_i;
  assign addr_ref[1] = addr_ref_b_i;
  assign data_ref[0] = data_ref_a_i;
  assign data_ref[1] = data_ref_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    lsw_cmp #(.W(ADDR_W)) i_addr_cmp (
      .value_i  (bus_addr_i),
      .ref_i    (addr_ref[g]),
      .op_i     (cmp_op_i[2*g +: 2]),
      .signed_i (1'b0),
      .hit_o    (a_hit[g]),
      .gt_o     (a_gt[g]),
      .lt_o     (a_lt[g])
    );
    lsw_cmp #(.W(DATA_W)) i_data_cmp (
      .value_i  (bus_data_i),
      .ref_i    (data_ref[g]),
      .op_i     (cmp_op_i[2*(g+2) +: 2]),
      .signed_i (data_signed_i[g]),
      .hit_o    (d_hit[g]),
      .gt_o     (d_gt[g]),
      .lt_o     (d_lt[g])
    );
  end

  lsw_pair i_addr_pair (
    .clk_i, .rst_ni,
    .hit_i  (a_hit),
    .gt_i   (a_gt),
    .lt_i   (a_lt),
    .mode_i (addr_pair_i),
    .res_o  (a_res)
  );

  lsw_pair i_data_pair (
    .clk_i, .rst_ni,
    .hit_i  (d_hit),
    .gt_i   (d_gt),
    .lt_i   (d_lt),
    .mode_i (data_pair_i),
    .res_o  (d_res)
  );

  assign qual = bus_valid_i & access_ok(bus_size_i, bus_addr_i[1:0]);

  lsw_andor #(.N_IW(N_IW), .N_WP(N_WP)) i_andor (
    .qual_i     (qual),
    .iw_i       (iw_i),
    .addr_hit_i (a_res),
    .data_hit_i (d_res),
    .wp_en_i    (wp_en_i),
    .iw_mask_i  (wp_iw_mask_i),
    .addr_sel_i (wp_addr_sel_i),
    .data_sel_i (wp_data_sel_i),
    .bp_sel_i   (bp_sel_i),
    .wp_o       (wp_d),
    .bp_o       (bp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsw_q <= '0;
      bp_q  <= 1'b0;
      bar_q <= '0;
    end else begin
      lsw_q <= wp_d;
      bp_q  <= bp_d;
      if (bp_d)          bar_q <= bus_addr_i;
      else if (bar_wr_i) bar_q <= bar_wdata_i;
    end
  end

  assign lsw_o       = lsw_q;
  assign lsw_pin_n_o = ~lsw_q;
  assign bp_o        = bp_q;
  assign bar_o       = bar_q;

  AST_VALID_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lsw_o) |-> $past(bus_valid_i)); // R7
  AST_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_size_i == SZ_WORD && bus_addr_i[1:0] != 2'b00) |=> (lsw_o == '0)); // R5
  AST_WP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsw_o & ~$past(wp_en_i)) == '0); // R6
  AST_BP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_o |-> ((lsw_o & $past(bp_sel_i)) != '0)); // R8
  AST_BAR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_o |-> (bar_o == $past(bus_addr_i))); // R10
  AST_BAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bp_o && !$past(bar_wr_i)) |-> $stable(bar_o)); // R10
endmodule

// File: tb/test_lsw_match_unit.sv
module test_lsw_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] addr = '0, data = '0;
  logic [1:0]  size = '0;
  logic [3:0]  iw = '0;
  logic [31:0] ara = '0, arb = '0, dra = '0, drb = '0;
  logic [7:0]  ops = '0;
  logic [1:0]  sgn = '0, apair = '0, dpair = '0, wen = '0, bsel = '0;
  logic [7:0]  mask = '0;
  logic [3:0]  asel = '0, dsel = '0;
  logic        bwr = 1'b0;
  logic [31:0] bwd = '0;
  logic [1:0]  lsw, pin_n;
  logic        bp;
  logic [31:0] bar;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";
  logic [31:0] bar_m = '0;
  logic [1:0]  exp_wp;
  logic        exp_bp;
  logic [31:0] exp_bar;

  always #2 clk = ~clk;

  lsw_match_unit i_lsw_match_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_addr_i(addr),
    .bus_data_i(data), .bus_size_i(size), .iw_i(iw),
    .addr_ref_a_i(ara), .addr_ref_b_i(arb), .data_ref_a_i(dra), .data_ref_b_i(drb),
    .cmp_op_i(ops), .data_signed_i(sgn), .addr_pair_i(apair), .data_pair_i(dpair),
    .wp_en_i(wen), .wp_iw_mask_i(mask), .wp_addr_sel_i(asel), .wp_data_sel_i(dsel),
    .bp_sel_i(bsel), .bar_wr_i(bwr), .bar_wdata_i(bwd),
    .lsw_o(lsw), .lsw_pin_n_o(pin_n), .bp_o(bp), .bar_o(bar)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_cmp(logic [31:0] v, logic [31:0] r, int op, bit s, output bit gt, output bit lt);
    longint sv, sr;
    sv = s ? longint'($signed(v)) : longint'({32'd0, v});
    sr = s ? longint'($signed(r)) : longint'({32'd0, r});
    gt = sv > sr;
    lt = sv < sr;
    case (op)
      0: return sv == sr;
      1: return sv != sr;
      2: return gt;
      default: return lt;
    endcase
  endfunction

  function automatic logic [1:0] m_pair(logic [31:0] v, logic [31:0] ra, logic [31:0] rb,
                                        int opa, int opb, bit sa, bit sb, int mode);
    bit ha, hb, ga, la, gb, lb, inr;
    ha = m_cmp(v, ra, opa, sa, ga, la);
    hb = m_cmp(v, rb, opb, sb, gb, lb);
    inr = ga && lb;
    if (mode == 1) return {inr, inr};
    if (mode == 2) return {!inr, !inr};
    return {hb, ha};
  endfunction

  function automatic bit m_term(int s, logic [1:0] h);
    if (s == 0) return 1'b1;
    if (s == 1) return h[0];
    if (s == 2) return h[1];
    return h[0] || h[1];
  endfunction

  task automatic model();
    bit al;
    logic [1:0] ah, dh;
    al = (size == 0) || (size == 1 && !addr[0]) || (size == 2 && addr[1:0] == 0);
    ah = m_pair(addr, ara, arb, ops[1:0], ops[3:2], 1'b0, 1'b0, apair);
    dh = m_pair(data, dra, drb, ops[5:4], ops[7:6], sgn[0], sgn[1], dpair);
    for (int k = 0; k < 2; k++) begin
      logic [3:0] mk;
      bit it;
      mk = mask[4*k +: 4];
      it = (mk == 0) || ((iw & mk) != 0);
      exp_wp[k] = valid && al && wen[k] && it && m_term(asel[2*k +: 2], ah) && m_term(dsel[2*k +: 2], dh);
    end
    exp_bp = (exp_wp & bsel) != 0;
    exp_bar = exp_bp ? addr : (bwr ? bwd : bar_m);
  endtask

  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, {30'd0, lsw}, {30'd0, exp_wp});
    chk("R8", {31'd0, bp}, {31'd0, exp_bp});
    chk("R9", {30'd0, pin_n}, {30'd0, ~lsw});
    chk("R10", bar, exp_bar);
    bar_m = exp_bar;
  endtask

  function automatic logic [31:0] near(logic [31:0] r);
    if ($urandom_range(0, 2) != 0) return r + 32'($urandom_range(0, 4)) - 32'd2;
    return $urandom;
  endfunction

  // phase knobs: 0 ops, 1 signed, 2 range, 3 sizes, 4 masks, 5 valid, 6 bp select / bar writes
  task automatic new_cfg(int ph);
    ara = $urandom & 32'hFFFF_FFFC; arb = ara + 32'($urandom_range(0, 64)) * 4;
    dra = $urandom; drb = dra + 32'($urandom_range(0, 40)) - 32'd8;
    if ($urandom_range(0, 1) != 0) begin dra = 32'hFFFF_FFF0 + 32'($urandom_range(0, 8)); drb = 32'd5; end
    ops = $urandom;
    sgn = (ph == 1 || ph >= 4) ? 2'($urandom) : 2'b00;
    apair = (ph == 2 || ph >= 4) ? 2'($urandom) : 2'd0;
    dpair = (ph == 2 || ph >= 4) ? 2'($urandom) : 2'd0;
    wen = (ph >= 4) ? 2'($urandom) : 2'b11;
    mask = (ph == 4 || ph >= 5) ? 8'($urandom) : 8'd0;
    asel = $urandom; dsel = $urandom;
    bsel = (ph == 6) ? 2'($urandom) : 2'b01;
  endtask

  task automatic new_bus(int ph);
    valid = (ph == 5 || ph == 6) ? 1'($urandom) : 1'b1;
    size = (ph == 3 || ph >= 5) ? 2'($urandom) : 2'd2;
    addr = ($urandom_range(0, 1) != 0) ? near(ara) : near(arb);
    if (ph != 3 && ph < 5) addr[1:0] = 2'b00;
    data = ($urandom_range(0, 1) != 0) ? near(dra) : near(drb);
    iw = $urandom;
    bwr = (ph == 6) ? 1'($urandom) : 1'b0;
    bwd = $urandom;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    string tags [7];
    tags = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8"};
    // R1 reset state with bus activity present
    valid = 1'b1; wen = 2'b11; bsel = 2'b11; size = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {30'd0, lsw}, 32'd0);
    chk("R1", {31'd0, bp}, 32'd0);
    chk("R1", {30'd0, pin_n}, 32'd3);
    chk("R1", bar, 32'd0);
    rst_n = 1'b1;
    valid = 1'b0; wen = 2'b00; bsel = 2'b00;
    step();

    // R5 directed: misaligned word never matches even with all terms true
    cur_req = "R5";
    wen = 2'b11; mask = 8'd0; asel = 4'd0; dsel = 4'd0; bsel = 2'b01; valid = 1'b1;
    size = 2'd2; addr = 32'h0000_1002; step();
    size = 2'd1; addr = 32'h0000_1001; step();
    size = 2'd1; addr = 32'h0000_1002; step();
    size = 2'd3; addr = 32'h0000_1000; step();
    // R10 directed: write then breakpoint beats write
    cur_req = "R10";
    valid = 1'b0; bwr = 1'b1; bwd = 32'hCAFE_0000; step();
    valid = 1'b1; size = 2'd0; addr = 32'h0000_2001; bwd = 32'h1111_1111; step();
    bwr = 1'b0; valid = 1'b0; step();

    for (int ph = 0; ph < 7; ph++) begin
      cur_req = tags[ph];
      for (int blk = 0; blk < 60; blk++) begin
        new_cfg(ph);
        for (int c = 0; c < 25; c++) begin
          new_bus(ph);
          step();
        end
      end
    end
    bwr = 1'b0; valid = 1'b0;
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule